// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by fetching short-format translation descriptors from memory. A request carries the virtual address and the translation base register. The walker makes a first-level read. Depending on the descriptor type, it either finishes there (a 1 MB section) or makes one more read into a coarse or a fine second-level table. The second-level descriptor maps a 64 KB, 4 KB or 1 KB page.

The memory side is a plain word-read port. The walker raises `mem_req` with a word address and holds both until a cycle in which `mem_rsp_valid` is high. That cycle returns the word, or it returns an error flag. When the walk ends, `done` pulses for one cycle. The result outputs stay unchanged until the next walk completes. The results are the physical address, a page-size code, the domain, the raw final descriptor, and the fault or abort status.

Top module: `xlat_walker`

## Requirements
- R1: Out of reset, `ready` is 1, `mem_req` is 0 and `done` is 0.
- R2: A request is accepted only when `ready` is 1. On the next cycle, `mem_req` rises with address {base[31:14], va[31:20], 2'b00}. The address and `mem_req` stay stable until the response cycle.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk with `fault`=1 and `fault_l2`=0.
- R4: A first-level descriptor with bits [1:0] = 10 (section) ends the walk with no second read. The result is pa = {d[31:20], va[19:0]}, `page_size` = 00 and domain = d[8:5].
- R5: A first-level descriptor with bits [1:0] = 01 (coarse) causes a second read at {d[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0] = 11 (fine) causes a second read at {d[31:12], va[19:10], 2'b00}.
- R7: For second-level descriptor e, bits [1:0] select the page. Type 01 gives pa = {e[31:16], va[15:0]} and size 01. Type 10 gives {e[31:12], va[11:0]} and size 10. Type 11 gives {e[31:10], va[9:0]} and size 11. The domain is taken from first-level bits [8:5].
- R8: A second-level descriptor with bits [1:0] = 00 ends the walk with `fault`=1 and `fault_l2`=1.
- R9: `mem_rsp_err` on either read ends the walk with `abort`=1 and `fault`=0. `fault_l2` shows which level was being read (0 = first, 1 = second).
- R10: `done` is a one-cycle pulse in the cycle after the final response. The results hold until the next walk ends. A request raised while the walker is busy is ignored.
- R11: `desc` carries the last descriptor word read, including in the fault case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a walk (taken when ready) |
| req_va | input | 32 | Virtual address |
| req_base | input | 32 | Translation base register; bits [31:14] used |
| ready | output | 1 | Walker idle |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Word read byte address |
| mem_rsp_valid | input | 1 | Read response this cycle |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read response is an error |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Translation fault |
| fault_l2 | output | 1 | Fault/abort level: 0 first, 1 second |
| abort | output | 1 | External abort from memory |
| pa | output | 32 | Physical address |
| page_size | output | 2 | 00 1M, 01 64K, 10 4K, 11 1K |
| domain | output | 4 | Domain from first-level descriptor |
| desc | output | 32 | Final descriptor word |

## Verification
Walks are driven through every first-level type: a section, coarse tables holding large and small pages, and a fine table holding a tiny page. The virtual and descriptor bits are chosen so that an off-by-one in any index width or frame split changes the checked address. Invalid descriptors at each level are compared with error responses at each level, to show that a fault and an abort are reported as different statuses with the correct level. A request injected while a read is outstanding, together with response delays, shows that the read address is held and that busy requests have no effect.

// File: rtl/xlat_walker.sv
module xlat_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  input  logic [31:0] req_base,
  output logic        ready,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        done,
  output logic        fault,
  output logic        fault_l2,
  output logic        abort,
  output logic [31:0] pa,
  output logic [1:0]  page_size,
  output logic [3:0]  domain,
  output logic [31:0] desc
);
  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2} st_t;

  st_t         st;
  logic [31:0] va_q;
  logic [17:0] base_q;
  logic [31:0] l2_addr_q;
  logic [3:0]  dom_q;
  logic [31:0] d;
  logic [31:0] l2_pa;
  logic        unused_bits;

  assign unused_bits = &{1'b0, req_base[13:0]};
  assign d        = mem_rsp_data;
  assign ready    = (st == S_IDLE);
  assign mem_req  = (st != S_IDLE);
  assign mem_addr = (st == S_L2) ? l2_addr_q : {base_q, va_q[31:20], 2'b00};

  always_comb begin
    case (d[1:0])
      2'b01:   l2_pa = {d[31:16], va_q[15:0]};
      2'b10:   l2_pa = {d[31:12], va_q[11:0]};
      default: l2_pa = {d[31:10], va_q[9:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; base_q <= '0; l2_addr_q <= '0; dom_q <= '0;
      done <= 1'b0; fault <= 1'b0; fault_l2 <= 1'b0; abort <= 1'b0;
      pa <= '0; page_size <= '0; domain <= '0; desc <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= req_base[31:14];
          st     <= S_L1;
        end
        S_L1: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            st <= S_IDLE; done <= 1'b1;
            abort <= 1'b1; fault <= 1'b0; fault_l2 <= 1'b0;
            pa <= '0; page_size <= '0; domain <= '0; desc <= d;
          end else begin
            case (d[1:0])
              2'b00: begin
                st <= S_IDLE; done <= 1'b1;
                abort <= 1'b0; fault <= 1'b1; fault_l2 <= 1'b0;
                pa <= '0; page_size <= '0; domain <= '0; desc <= d;
              end
              2'b10: begin
                st <= S_IDLE; done <= 1'b1;
                abort <= 1'b0; fault <= 1'b0; fault_l2 <= 1'b0;
                pa <= {d[31:20], va_q[19:0]}; page_size <= 2'b00;
                domain <= d[8:5]; desc <= d;
              end
              2'b01: begin
                st <= S_L2; dom_q <= d[8:5];
                l2_addr_q <= {d[31:10], va_q[19:12], 2'b00};
              end
              default: begin
                st <= S_L2; dom_q <= d[8:5];
                l2_addr_q <= {d[31:12], va_q[19:10], 2'b00};
              end
            endcase
          end
        end
        S_L2: if (mem_rsp_valid) begin
          st <= S_IDLE; done <= 1'b1;
          fault_l2 <= 1'b1; domain <= dom_q; desc <= d;
          if (mem_rsp_err) begin
            abort <= 1'b1; fault <= 1'b0; pa <= '0; page_size <= '0;
          end else if (d[1:0] == 2'b00) begin
            abort <= 1'b0; fault <= 1'b1; pa <= '0; page_size <= '0;
          end else begin
            abort <= 1'b0; fault <= 1'b0; pa <= l2_pa; page_size <= d[1:0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_va,
  input logic [31:0] req_base,
  input logic        ready,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic        fault,
  input logic        abort
);
  AST_L1_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> (mem_req && mem_addr == {$past(req_base[31:14]), $past(req_va[31:20]), 2'b00})); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr))); // R2
  AST_FAULT_XOR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(fault && abort)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_req && mem_rsp_valid)); // R10
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req); // R1
endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_va = '0, req_base = '0;
  logic ready, mem_req, done, fault, fault_l2, abort;
  logic [31:0] mem_addr, pa, desc;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [1:0] page_size;
  logic [3:0] domain;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_walker u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(logic [31:0] va, logic [31:0] base);
    @(negedge clk);
    chk("R10 ready before request", {31'b0, ready}, 32'd1);
    req_va = va; req_base = base; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 mem_req after accept", {31'b0, mem_req}, 32'd1);
    chk("R2 L1 address", mem_addr, {base[31:14], va[31:20], 2'b00});
  endtask

  task automatic serve(string tag, logic [31:0] exp_addr, logic [31:0] data, bit err, int dly);
    chk({tag, " read address"}, mem_addr, exp_addr);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R2 address held while waiting", {mem_req, mem_addr[30:0]}, {1'b1, exp_addr[30:0]});
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = data; mem_rsp_err = err;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
  endtask

  task automatic result(string tag, bit f, bit lvl, bit ab, logic [31:0] epa,
                        logic [1:0] sz, logic [3:0] dom, logic [31:0] d);
    chk({tag, " R10 done"}, {31'b0, done}, 32'd1);
    chk({tag, " fault"}, {31'b0, fault}, {31'b0, f});
    chk({tag, " level"}, {31'b0, fault_l2}, {31'b0, lvl});
    chk({tag, " R9 abort"}, {31'b0, abort}, {31'b0, ab});
    if (!f && !ab) begin
      chk({tag, " pa"}, pa, epa);
      chk({tag, " size"}, {30'b0, page_size}, {30'b0, sz});
      chk({tag, " domain"}, {28'b0, domain}, {28'b0, dom});
    end
    chk({tag, " R11 desc"}, desc, d);
    chk({tag, " R4 no further read"}, {31'b0, mem_req}, 32'd0);
    @(negedge clk);
    chk({tag, " R10 done pulse ends"}, {31'b0, done}, 32'd0);
    chk({tag, " R10 desc held"}, desc, d);
  endtask

  task automatic t_reset();
    chk("R1 ready", {31'b0, ready}, 32'd1);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
  endtask

  task automatic t_section();
    logic [31:0] va = 32'h1234_5678, base = 32'h8000_7FFF, d1 = 32'hABC0_0CA2;
    start(va, base);
    serve("R4 section", {base[31:14], va[31:20], 2'b00}, d1, 0, 2);
    result("R4 section", 0, 0, 0, {d1[31:20], va[19:0]}, 2'b00, d1[8:5], d1);
    chk("R10 pa held", pa, {d1[31:20], va[19:0]});
  endtask

  task automatic t_coarse(logic [31:0] d2, logic [1:0] sz, string tag);
    logic [31:0] va = 32'hCAFE_BABE, base = 32'h0001_C000, d1 = 32'h0012_3461;
    logic [31:0] epa;
    start(va, base);
    serve("R5 coarse L1", {base[31:14], va[31:20], 2'b00}, d1, 0, 0);
    chk("R5 second read", {31'b0, mem_req}, 32'd1);
    serve("R5 coarse L2", {d1[31:10], va[19:12], 2'b00}, d2, 0, 1);
    epa = (sz == 2'b01) ? {d2[31:16], va[15:0]} : {d2[31:12], va[11:0]};
    result(tag, 0, 1, 0, epa, sz, d1[8:5], d2);
  endtask

  task automatic t_fine_tiny();
    logic [31:0] va = 32'h7654_3F21, base = 32'hFFFF_C000, d1 = 32'h0045_61E3, d2 = 32'h9999_9C03;
    start(va, base);
    serve("R6 fine L1", {base[31:14], va[31:20], 2'b00}, d1, 0, 1);
    serve("R6 fine L2", {d1[31:12], va[19:10], 2'b00}, d2, 0, 0);
    result("R7 tiny", 0, 1, 0, {d2[31:10], va[9:0]}, 2'b11, d1[8:5], d2);
  endtask

  task automatic t_l1_fault();
    logic [31:0] va = 32'h0010_0000, base = 32'h0000_4000, d1 = 32'hFFFF_FFFC;
    start(va, base);
    serve("R3 L1 fault", {base[31:14], va[31:20], 2'b00}, d1, 0, 0);
    result("R3 L1 fault", 1, 0, 0, 0, 0, 0, d1);
  endtask

  task automatic t_l2_fault();
    logic [31:0] va = 32'h0030_5000, base = 32'h0000_4000, d1 = 32'h0000_8021, d2 = 32'h1234_5670;
    start(va, base);
    serve("R8 L1", {base[31:14], va[31:20], 2'b00}, d1, 0, 0);
    serve("R8 L2", {d1[31:10], va[19:12], 2'b00}, d2, 0, 0);
    result("R8 L2 fault", 1, 1, 0, 0, 0, 0, d2);
  endtask

  task automatic t_aborts();
    logic [31:0] va = 32'h4444_4444, base = 32'h0000_8000, d1 = 32'h0000_C003;
    start(va, base);
    serve("R9 L1 abort", {base[31:14], va[31:20], 2'b00}, 32'h0000_0002, 1, 1);
    result("R9 L1 abort", 0, 0, 1, 0, 0, 0, 32'h0000_0002);
    start(va, base);
    serve("R9 L1 ok", {base[31:14], va[31:20], 2'b00}, d1, 0, 0);
    serve("R9 L2 abort", {d1[31:12], va[19:10], 2'b00}, 32'h0000_0002, 1, 0);
    result("R9 L2 abort", 0, 1, 1, 0, 0, 0, 32'h0000_0002);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] va = 32'hF0F0_1234, base = 32'h0000_4000, d1 = 32'h5A50_0002;
    start(va, base);
    chk("R10 not ready while busy", {31'b0, ready}, 32'd0);
    req_va = 32'h0FF0_0000; req_base = 32'hFFFF_C000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy request ignored", mem_addr, {base[31:14], va[31:20], 2'b00});
    serve("R10 busy", {base[31:14], va[31:20], 2'b00}, d1, 0, 1);
    result("R10 busy", 0, 0, 0, {d1[31:20], va[19:0]}, 2'b00, d1[8:5], d1);
    chk("R10 idle after walk", {31'b0, ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_section();
    t_coarse(32'h5555_6002, 2'b10, "R7 small");
    t_coarse(32'h7777_0001, 2'b01, "R7 large");
    t_fine_tiny();
    t_l1_fault();
    t_l2_fault();
    t_aborts();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule